// File: doc/BRIEF.md
# CRC-32 Register Bank with Buffered Feed

This block computes a running CRC-32 over data that software writes through a simple 32-bit synchronous register bus. Every write to the data register folds 8, 16 or 32 bits into the stored checksum. The number of bits depends on the byte strobes of that access, so a message of any length can be handled with the fewest writes. A read of the same register returns the checksum. The read value can be bit-reversed, and each write can be bit-reversed in 8-, 16- or 32-bit units before it enters the calculation. This covers the common ways of ordering bits across endianness.

The generator is fixed at 0x04C11DB7. Bits are shifted in most significant first and no final XOR is applied. Software chooses the starting value in an initial-value register. The running checksum reloads from that register when the initial value is written, or when software sets the self-clearing restart bit in the control register. A scratch byte register is also provided and the restart bit does not disturb it. The datapath handles one byte per clock. A single-entry holding stage lets a second data write complete while the first is still being processed. When a transaction cannot be served yet, the bus is held off with `bus_ready` low.

Top module: `crc32_regbank`

## Requirements
- R1: After a synchronous reset, reads return 0xFFFFFFFF from the checksum (offset 0x00) and from the initial value (offset 0x10), and 0 from the scratch register (offset 0x04) and from control (offset 0x08).
- R2: Each input byte updates the checksum with polynomial 0x04C11DB7, bit 7 of the byte first, with no output XOR. The nine ASCII bytes "123456789" written from seed 0xFFFFFFFF give 0x0376E6E7.
- R3: The strobes of a write to offset 0x00 set the input width: 4'b0001 takes wdata[7:0], 4'b0011 takes wdata[15:0] and 4'b1111 takes all 32 bits. The most significant byte of the input goes in first, so one word write followed by one byte write equals the same five bytes written one at a time. Any other strobe pattern at 0x00 is dropped and leaves the checksum unchanged.
- R4: Control bits [6:5] reverse the bit order of the input before it is used. The codes are 0 for none, 1 for within each byte, 2 for within each 16-bit half and 3 for the whole word. The unit of reversal never exceeds the width of the access.
- R5: When control bit 7 is 1, a read of offset 0x00 returns the checksum with all 32 bits reversed. For example, 0x11223344 reads back as 0x22CC4488.
- R6: A full-width control write with bit 0 set loads the checksum from the initial-value register. Bit 0 always reads back as 0, and control reads return only bits [7:5] besides it.
- R7: A full-width write to offset 0x10 stores the initial value and also copies it into the checksum.
- R8: The scratch register keeps wdata[7:0] of a full-width write, reads zeros in bits [31:8], and is not changed by the restart bit.
- R9: Writes to offsets 0x04, 0x08 and 0x10 take effect only when all four strobes are set. Other strobe patterns complete without any effect.
- R10: The datapath handles one byte per clock. A data write is accepted while the holding stage is empty or the datapath is on its last byte, and stalls otherwise. A checksum read and any full-width control or initial-value write stall until the datapath and the holding stage are both empty.
- R11: Reads from unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A transaction is presented |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 4 | Byte strobes of a write |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid while a read is presented and ready is high, otherwise 0 |
| bus_ready | output | 1 | The presented transaction completes at the next rising edge |

## Verification
The hardest situation to reach is a data write that arrives exactly when the datapath is on its last byte and the holding stage is full. In that cycle the held entry moves into the datapath while the new write takes its place. To get there, the stimulus issues back-to-back word writes with no idle cycles between them. The third write then waits a precise number of cycles, and that wait is checked directly. A behavioural model that tracks the remaining bytes and a queue of held entries predicts `bus_ready` and every read value on each clock. The model is checked through long random mixes of widths, strobes, reversal modes, restarts and reads.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned BE_W    = WORD_W / 8;
    localparam int unsigned CNT_W   = $clog2(BE_W + 1);

    localparam logic [WORD_W-1:0] GEN_POLY  = 32'h04C11DB7;
    localparam logic [WORD_W-1:0] SEED_INIT = 32'hFFFFFFFF;

    localparam logic [ADDR_W-1:0] OFS_SUM     = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SEED    = 5'h10;

    typedef enum logic [1:0] {
        FLIP_NONE = 2'd0,
        FLIP_BYTE = 2'd1,
        FLIP_HALF = 2'd2,
        FLIP_WORD = 2'd3
    } flip_mode_e;

    typedef struct packed {
        logic       out_flip;
        flip_mode_e in_flip;
    } ctrl_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
    } feed_t;

    function automatic logic [WORD_W-1:0] crc_step8(input logic [WORD_W-1:0] c,
                                                    input logic [7:0] d);
        logic [WORD_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ d[i];
            r  = {r[WORD_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_POLY;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] flip_word(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < int'(WORD_W); i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] strobe_width(input logic [BE_W-1:0] be);
        case (be)
            4'b0001: return CNT_W'(1);
            4'b0011: return CNT_W'(2);
            4'b1111: return CNT_W'(4);
            default: return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/crc32_inflip.sv
module crc32_inflip
    import crc32_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic [CNT_W-1:0]  nbytes_i,
    input  flip_mode_e        mode_i,
    output logic [WORD_W-1:0] data_o
);
    localparam int unsigned HALVES = WORD_W / 16;

    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] by8;
    logic [WORD_W-1:0] by16;
    logic [WORD_W-1:0] by32;

    always_comb begin
        case (nbytes_i)
            CNT_W'(1): masked = {24'h0, data_i[7:0]};
            CNT_W'(2): masked = {16'h0, data_i[15:0]};
            default:   masked = data_i;
        endcase
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign by8[b*8+k] = masked[b*8+7-k];
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        for (genvar k = 0; k < 16; k++) begin : g_bit
            assign by16[h*16+k] = masked[h*16+15-k];
        end
    end

    assign by32 = flip_word(masked);

    always_comb begin
        case (mode_i)
            FLIP_BYTE: data_o = by8;
            FLIP_HALF: data_o = (nbytes_i == CNT_W'(1)) ? by8 : by16;
            FLIP_WORD: begin
                if (nbytes_i == CNT_W'(1))      data_o = by8;
                else if (nbytes_i == CNT_W'(2)) data_o = by16;
                else                            data_o = by32;
            end
            default:   data_o = masked;
        endcase
    end
endmodule

// File: rtl/crc32_engine.sv
module crc32_engine
    import crc32_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_SUM = SEED_INIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              feed_valid,
    input  feed_t             feed,
    output logic              feed_ready,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_val,
    output logic [WORD_W-1:0] sum,
    output logic [CNT_W-1:0]  left,
    output logic              hold_full
);
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] shift_q;
    logic [CNT_W-1:0]  left_q;
    feed_t             hold_q;
    logic              hold_full_q;
    logic              last_byte;
    logic [WORD_W-1:0] stepped;

    function automatic logic [WORD_W-1:0] top_align(input feed_t f);
        case (f.nbytes)
            CNT_W'(1): return {f.data[7:0], 24'h0};
            CNT_W'(2): return {f.data[15:0], 16'h0};
            default:   return f.data;
        endcase
    endfunction

    assign last_byte  = (left_q == CNT_W'(1));
    assign feed_ready = !hold_full_q || last_byte;
    assign stepped    = crc_step8(sum_q, shift_q[WORD_W-1 -: 8]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q       <= RESET_SUM;
            shift_q     <= '0;
            left_q      <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (load_en) begin
            sum_q <= load_val;
        end else if (left_q > CNT_W'(1)) begin
            sum_q   <= stepped;
            shift_q <= shift_q << 8;
            left_q  <= left_q - CNT_W'(1);
            if (feed_valid) begin
                hold_q      <= feed;
                hold_full_q <= 1'b1;
            end
        end else begin
            if (last_byte) sum_q <= stepped;
            if (hold_full_q) begin
                shift_q     <= top_align(hold_q);
                left_q      <= hold_q.nbytes;
                hold_q      <= feed;
                hold_full_q <= feed_valid;
            end else if (feed_valid) begin
                shift_q <= top_align(feed);
                left_q  <= feed.nbytes;
            end else begin
                left_q <= '0;
            end
        end
    end

    assign sum       = sum_q;
    assign left      = left_q;
    assign hold_full = hold_full_q;
endmodule

// File: rtl/crc32_regbank.sv
module crc32_regbank
    import crc32_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_SEED = SEED_INIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ready
);
    logic [WORD_W-1:0] seed_q;
    logic [7:0]        scratch_q;
    ctrl_t             ctrl_q;

    logic [WORD_W-1:0] crc_q;
    logic [CNT_W-1:0]  eng_cnt;
    logic              buf_full;
    logic              feed_ready;

    logic sel_sum, sel_scratch, sel_ctrl, sel_seed;
    logic rd_req, wr_req, full_be, fire, idle;
    logic [CNT_W-1:0]  width;
    logic [WORD_W-1:0] flipped;
    logic              feed_valid;
    feed_t             feed;
    logic              load_en;
    logic [WORD_W-1:0] load_val;

    assign sel_sum     = (bus_addr == OFS_SUM);
    assign sel_scratch = (bus_addr == OFS_SCRATCH);
    assign sel_ctrl    = (bus_addr == OFS_CTRL);
    assign sel_seed    = (bus_addr == OFS_SEED);
    assign rd_req      = bus_valid && !bus_we;
    assign wr_req      = bus_valid && bus_we;
    assign full_be     = (bus_be == {BE_W{1'b1}});
    assign width       = strobe_width(bus_be);
    assign idle        = (eng_cnt == '0) && !buf_full;

    always_comb begin
        bus_ready = 1'b1;
        if (sel_sum) begin
            if (wr_req && width != '0) bus_ready = feed_ready;
            if (rd_req)                bus_ready = idle;
        end
        if ((sel_ctrl || sel_seed) && wr_req && full_be) bus_ready = idle;
    end

    assign fire = bus_valid && bus_ready;

    crc32_inflip u_inflip (
        .data_i   (bus_wdata),
        .nbytes_i (width),
        .mode_i   (ctrl_q.in_flip),
        .data_o   (flipped)
    );

    assign feed_valid  = fire && bus_we && sel_sum && (width != '0);
    assign feed.data   = flipped;
    assign feed.nbytes = width;

    assign load_en  = fire && bus_we && full_be &&
                      ((sel_ctrl && bus_wdata[0]) || sel_seed);
    assign load_val = sel_seed ? bus_wdata : seed_q;

    crc32_engine #(
        .RESET_SUM (RESET_SEED)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .feed_valid (feed_valid),
        .feed       (feed),
        .feed_ready (feed_ready),
        .load_en    (load_en),
        .load_val   (load_val),
        .sum        (crc_q),
        .left       (eng_cnt),
        .hold_full  (buf_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q    <= RESET_SEED;
            scratch_q <= '0;
            ctrl_q    <= '0;
        end else if (fire && bus_we && full_be) begin
            if (sel_seed)    seed_q    <= bus_wdata;
            if (sel_scratch) scratch_q <= bus_wdata[7:0];
            if (sel_ctrl) begin
                ctrl_q.out_flip <= bus_wdata[7];
                ctrl_q.in_flip  <= flip_mode_e'(bus_wdata[6:5]);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_req && bus_ready) begin
            if (sel_sum)     bus_rdata = ctrl_q.out_flip ? flip_word(crc_q) : crc_q;
            if (sel_scratch) bus_rdata = {24'h0, scratch_q};
            if (sel_ctrl)    bus_rdata = {24'h0, ctrl_q.out_flip, ctrl_q.in_flip, 5'b0};
            if (sel_seed)    bus_rdata = seed_q;
        end
    end
endmodule

// File: rtl/crc32_regbank_chk.sv
module crc32_regbank_chk
    import crc32_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic [CNT_W-1:0]  eng_cnt,
    input logic              buf_full,
    input logic [WORD_W-1:0] crc_q
);
    // R10: a held entry only exists behind a busy datapath
    a_r10_hold_behind_busy: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> (eng_cnt != '0));

    // R10: checksum reads wait for an empty pipeline
    a_r10_read_waits: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && bus_addr == OFS_SUM && (eng_cnt != '0 || buf_full))
        |-> !bus_ready);

    // R10: one byte per clock
    a_r10_one_byte_per_clock: assert property (@(posedge clk) disable iff (rst)
        (eng_cnt > CNT_W'(1)) |=> (eng_cnt == $past(eng_cnt) - CNT_W'(1)));

    // R7: writing the seed copies it into the checksum
    a_r7_seed_copies: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && bus_we && bus_addr == OFS_SEED && bus_be == 4'hF)
        |=> (crc_q == $past(bus_wdata)));

    // R6: restart bit never reads back as set
    a_r6_restart_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && bus_ready && bus_addr == OFS_CTRL) |-> !bus_rdata[0]);

    // R8: scratch upper bits are zero
    a_r8_scratch_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && bus_ready && bus_addr == OFS_SCRATCH)
        |-> (bus_rdata[31:8] == 24'h0));

    // R3: an unsupported strobe pattern starts no work on an idle datapath
    a_r3_bad_strobe_dropped: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_addr == OFS_SUM && eng_cnt == '0 && !buf_full &&
         bus_be != 4'b0001 && bus_be != 4'b0011 && bus_be != 4'b1111)
        |=> (eng_cnt == '0));
endmodule

bind crc32_regbank crc32_regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .eng_cnt   (eng_cnt),
    .buf_full  (buf_full),
    .crc_q     (crc_q)
);

// File: tb/tb_crc32_regbank.sv
module tb_crc32_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    crc32_regbank dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_crc, m_seed;
    logic [7:0]  m_scratch;
    logic        m_oflip;
    int          m_iflip;
    int          m_left;
    int          m_hold[$];

    function automatic int be_bytes(input logic [3:0] be);
        if (be == 4'b0001) return 1;
        if (be == 4'b0011) return 2;
        if (be == 4'b1111) return 4;
        return 0;
    endfunction

    function automatic logic [31:0] rev_all(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] ref_flip(input logic [31:0] v, input int n, input int mode);
        logic [31:0] r = '0;
        int unit;
        unit = (mode == 1) ? 8 : (mode == 2) ? 16 : (mode == 3) ? 32 : 0;
        if (unit > n * 8) unit = n * 8;
        for (int i = 0; i < n * 8; i++) begin
            if (unit == 0) r[i] = v[i];
            else r[(i / unit) * unit + unit - 1 - (i % unit)] = v[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] v, input int n);
        logic [31:0] r = c;
        for (int i = n * 8 - 1; i >= 0; i--) begin
            logic fb;
            fb = r[31] ^ v[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic m_ready();
        bit idle_m;
        idle_m = (m_left == 0) && (m_hold.size() == 0);
        if (bus_addr == 5'h00) begin
            if (bus_we && be_bytes(bus_be) != 0) return (m_hold.size() == 0) || (m_left == 1);
            if (!bus_we) return idle_m;
        end
        if ((bus_addr == 5'h08 || bus_addr == 5'h10) && bus_we && bus_be == 4'hF) return idle_m;
        return 1'b1;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_oflip ? rev_all(m_crc) : m_crc;
            5'h04: return {24'h0, m_scratch};
            5'h08: return {24'h0, m_oflip, 2'(m_iflip), 5'b0};
            5'h10: return m_seed;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_crc = 32'hFFFFFFFF; m_seed = 32'hFFFFFFFF; m_scratch = 8'h0;
            m_oflip = 1'b0; m_iflip = 0; m_left = 0; m_hold.delete();
        end else begin
            bit acc;
            int n;
            bit acc_dr;
            acc = bus_valid && m_ready();
            n = be_bytes(bus_be);
            acc_dr = acc && bus_we && bus_addr == 5'h00 && n != 0;
            if (m_left > 1) begin
                m_left--;
                if (acc_dr) m_hold.push_back(n);
            end else if (m_hold.size() > 0) begin
                m_left = m_hold.pop_front();
                if (acc_dr) m_hold.push_back(n);
            end else begin
                m_left = acc_dr ? n : 0;
            end
            if (acc_dr) m_crc = ref_crc(m_crc, ref_flip(bus_wdata, n, m_iflip), n);
            if (acc && bus_we && bus_be == 4'hF) begin
                if (bus_addr == 5'h04) m_scratch = bus_wdata[7:0];
                if (bus_addr == 5'h10) begin m_seed = bus_wdata; m_crc = bus_wdata; end
                if (bus_addr == 5'h08) begin
                    m_oflip = bus_wdata[7];
                    m_iflip = int'(bus_wdata[6:5]);
                    if (bus_wdata[0]) m_crc = m_seed;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && bus_valid) begin
            checks++;
            if (bus_ready !== m_ready()) begin
                errors++;
                $display("FAIL R10 ready addr=%h got %b exp %b", bus_addr, bus_ready, m_ready());
            end
            if (!bus_we && bus_ready && m_ready()) begin
                checks++;
                if (bus_rdata !== m_read(bus_addr)) begin
                    errors++;
                    $display("FAIL %s read addr=%h got %h exp %h",
                             bus_addr == 5'h00 ? "R2/R4/R5" : bus_addr == 5'h04 ? "R8" :
                             bus_addr == 5'h08 ? "R6" : bus_addr == 5'h10 ? "R9" : "R11",
                             bus_addr, bus_rdata, m_read(bus_addr));
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic xact(input logic we, input logic [4:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output int waits);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        waits = 0;
        forever begin
            @(negedge clk);
            if (bus_ready) begin rd = bus_rdata; break; end
            waits++;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] x; int w;
        xact(1'b1, a, be, d, x, w);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        int w;
        xact(1'b0, a, 4'h0, 32'h0, v, w);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; bus_valid = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [31:0] v, a1, b1;
        int w;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        rd(5'h00, v); chk("R1 sum reset", v, 32'hFFFFFFFF);
        rd(5'h10, v); chk("R1 seed reset", v, 32'hFFFFFFFF);
        rd(5'h04, v); chk("R1 scratch reset", v, 32'h0);
        rd(5'h08, v); chk("R1 ctrl reset", v, 32'h0);

        // R2: check vector
        for (int i = 0; i < 9; i++) wr(5'h00, 4'b0001, 32'h31 + i);
        rd(5'h00, v); chk("R2 check vector", v, 32'h0376E6E7);

        // R3: word + byte equals five bytes
        wr(5'h10, 4'hF, 32'hFFFFFFFF);
        wr(5'h00, 4'hF, 32'h11223344); wr(5'h00, 4'b0001, 32'hABCDEF55);
        rd(5'h00, a1);
        wr(5'h10, 4'hF, 32'hFFFFFFFF);
        for (int i = 1; i <= 5; i++) wr(5'h00, 4'b0001, 32'(i * 8'h11));
        rd(5'h00, b1); chk("R3 word+byte vs bytes", a1, b1);
        wr(5'h00, 4'b0010, 32'hDEADBEEF);
        rd(5'h00, v); chk("R3 bad strobe ignored", v, b1);

        // R4: input flip equivalences
        wr(5'h10, 4'hF, 32'h0);
        wr(5'h08, 4'hF, 32'h60);
        wr(5'h00, 4'hF, 32'h12345678); rd(5'h00, a1);
        wr(5'h08, 4'hF, 32'h0); wr(5'h10, 4'hF, 32'h0);
        wr(5'h00, 4'hF, 32'h1E6A2C48); rd(5'h00, b1);
        chk("R4 word flip", a1, b1);
        wr(5'h08, 4'hF, 32'h60); wr(5'h10, 4'hF, 32'h0);
        wr(5'h00, 4'b0001, 32'hFF01); rd(5'h00, a1);
        wr(5'h08, 4'hF, 32'h0); wr(5'h10, 4'hF, 32'h0);
        wr(5'h00, 4'b0001, 32'h80); rd(5'h00, b1);
        chk("R4 word flip clipped to byte", a1, b1);

        // R5: output flip
        wr(5'h10, 4'hF, 32'h11223344);
        wr(5'h08, 4'hF, 32'h80);
        rd(5'h00, v); chk("R5 output flip", v, 32'h22CC4488);

        // R6/R8: restart and scratch
        wr(5'h04, 4'hF, 32'hABCDEF5A);
        wr(5'h00, 4'hF, 32'hCAFEF00D);
        wr(5'h08, 4'hF, 32'h01);
        rd(5'h00, v); chk("R6 restart loads seed", v, 32'h11223344);
        rd(5'h08, v); chk("R6 restart bit clear", v, 32'h0);
        rd(5'h04, v); chk("R8 scratch kept", v, 32'h5A);

        // R9/R7: partial strobes on other registers
        wr(5'h10, 4'h7, 32'h0);
        rd(5'h10, v); chk("R9 seed partial ignored", v, 32'h11223344);
        wr(5'h10, 4'hF, 32'h89ABCDEF);
        rd(5'h00, v); chk("R7 seed copied", v, 32'h89ABCDEF);

        // R11: unmapped
        wr(5'h0C, 4'hF, 32'hFFFFFFFF);
        rd(5'h0C, v); chk("R11 unmapped reads zero", v, 32'h0);
        rd(5'h00, v); chk("R11 unmapped write no effect", v, 32'h89ABCDEF);

        // R10: latency and holding stage
        wr(5'h00, 4'hF, 32'h1); xact(1'b0, 5'h00, 4'h0, 32'h0, v, w);
        chk("R10 word read wait", 32'(w), 32'd4);
        wr(5'h00, 4'b0001, 32'h1); xact(1'b0, 5'h00, 4'h0, 32'h0, v, w);
        chk("R10 byte read wait", 32'(w), 32'd1);
        wr(5'h00, 4'hF, 32'h2);
        xact(1'b1, 5'h00, 4'hF, 32'h3, v, w); chk("R10 buffered write no wait", 32'(w), 32'd0);
        xact(1'b1, 5'h00, 4'hF, 32'h4, v, w); chk("R10 third write wait", 32'(w), 32'd2);
        idle(8);

        // random mix checked against the model every cycle
        for (int i = 0; i < 600; i++) begin
            logic [4:0] a; logic [3:0] be; int s;
            s = $urandom_range(0, 9);
            a = (s < 5) ? 5'h00 : (s == 5) ? 5'h04 : (s == 6) ? 5'h08 : (s == 7) ? 5'h10 : 5'h0C;
            s = $urandom_range(0, 4);
            be = (s == 0) ? 4'b0001 : (s == 1) ? 4'b0011 : (s == 2) ? 4'b0110 : 4'hF;
            if ($urandom_range(0, 9) == 0) idle(1);
            else xact($urandom_range(0, 2) != 0, a, be, $urandom, v, w);
        end
        idle(8);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule